// File: doc/BRIEF.md
# Locked Bus Sequence Monitor

This block sits beside a processor bus and watches each transfer strobe together with the bus lock signal. It checks that a locked read is always closed by a locked write before the lock is released, which is how a read-modify-write sequence must look on the bus. It also watches for the pattern that hangs the bus. That pattern is a second locked read issued while the first is still unmatched. A locked fetch of an exception vector, which is two back-to-back reads, produces it.

The monitor reports three kinds of fault: a repeated locked read, a lock released over an unmatched read, and a lock held with no bus traffic for a programmable number of cycles. When the first fault is seen, the monitor latches a sticky flag, a cause code and the address involved, and it gives a one-cycle pulse. It then ignores the bus until software or a neighbouring block pulses the clear input. Bus arbitration and any recovery action belong to other logic.

Top module: `lock_seq_monitor`

## Requirements
- R1: A locked read followed by a locked write, each a one-cycle strobe with `busLock` high, raises no fault, and the monitor is then idle, so a following locked read and locked write pair is also clean.
- R2: Reads and writes with `busLock` low, issued while no locked read is open, never change the monitor and never raise a fault.
- R3: A second locked read with no locked write after an open locked read raises a fault with cause code 1, and `violAddr` holds the address of that second read.
- R4: Dropping `busLock` while a locked read is still unmatched raises a fault with cause code 2, and `violAddr` holds the address of the unmatched read.
- R5: When `busLock` is high with neither strobe for `stallLimit` consecutive cycles, a fault is raised with cause code 3. `violAddr` then holds the address of the most recent locked read. A `stallLimit` of 0 turns this check off.
- R6: Every fault is reported on the clock edge that samples the offending bus cycle. `violPulse` is high for exactly one cycle, and `violSticky` stays high afterwards. While it is high, further bus activity gives no new pulse and leaves `violAddr` and `violCause` unchanged.
- R7: A cycle with `clearViol` high sets `violSticky`, `violCause` and `violAddr` to zero and returns the monitor to idle. Any bus strobe sampled in that same cycle is ignored.
- R8: After reset, `violSticky` and `violPulse` are low, and `violCause` and `violAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdStb | input | 1 | One-cycle read transfer strobe |
| wrStb | input | 1 | One-cycle write transfer strobe |
| busAddr | input | ADDR_W | Address of the transfer |
| busLock | input | 1 | Bus lock, active high |
| stallLimit | input | CNT_W | Quiet locked cycles before a stall fault; 0 disables the check |
| clearViol | input | 1 | Clears the latched fault |
| violSticky | output | 1 | Fault latched |
| violPulse | output | 1 | One-cycle pulse when a fault is latched |
| violCause | output | 2 | 0 none, 1 repeated locked read, 2 lock dropped, 3 stall |
| violAddr | output | ADDR_W | Address tied to the fault |

## Verification
Every output is a register loaded on the edge that samples the offending bus cycle, so each result appears one clock after its stimulus is driven. The bench drives inputs on the falling edge and reads the outputs one time unit after the next rising edge. Each fault is checked in that exact cycle, and the pulse is checked again one cycle later to confirm it has fallen. For the stall case, the bench checks that no fault is present after `stallLimit`-1 quiet cycles and that the fault appears after exactly `stallLimit` quiet cycles.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_DOUBLE = 2'd1,
    CAUSE_DROP   = 2'd2,
    CAUSE_STALL  = 2'd3
  } violCause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_AWAIT = 2'd1,
    ST_HALT  = 2'd2
  } monState_e;

  typedef struct packed {
    logic       loadPend;
    logic       raise;
    logic       clear;
    violCause_e cause;
  } lsmStrobe_t;
endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic             busLock,
  input  logic [CNT_W-1:0] stallLimit,
  input  logic             clearViol,
  output lsmStrobe_t       strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  monState_e        stateQ, stateD;
  logic [CNT_W-1:0] quietCnt;
  logic             quiet, lockedRd, lockedWr, stallHit;

  assign quiet    = busLock && !rdStb && !wrStb;
  assign lockedRd = busLock && rdStb;
  assign lockedWr = busLock && wrStb && !rdStb;
  assign stallHit = quiet && (stallLimit != '0) &&
                    ({1'b0, quietCnt} + 1'b1 == {1'b0, stallLimit});

  always_comb begin
    stateD = stateQ;
    strobe = '{loadPend: 1'b0, raise: 1'b0, clear: 1'b0, cause: CAUSE_NONE};
    if (clearViol) begin
      stateD       = ST_IDLE;
      strobe.clear = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (lockedRd) begin
            stateD          = ST_AWAIT;
            strobe.loadPend = 1'b1;
          end else if (stallHit) begin
            stateD       = ST_HALT;
            strobe.raise = 1'b1;
            strobe.cause = CAUSE_STALL;
          end
        end
        ST_AWAIT: begin
          if (lockedRd) begin
            stateD       = ST_HALT;
            strobe.raise = 1'b1;
            strobe.cause = CAUSE_DOUBLE;
          end else if (lockedWr) begin
            stateD = ST_IDLE;
          end else if (!busLock) begin
            stateD       = ST_HALT;
            strobe.raise = 1'b1;
            strobe.cause = CAUSE_DROP;
          end else if (stallHit) begin
            stateD       = ST_HALT;
            strobe.raise = 1'b1;
            strobe.cause = CAUSE_STALL;
          end
        end
        default: stateD = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      quietCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (clearViol || !quiet || stallHit || stateQ == ST_HALT)
        quietCnt <= '0;
      else if (quietCnt != CNT_MAX)
        quietCnt <= quietCnt + 1'b1;
    end
  end

  // R1
  open_on_locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !clearViol && busLock && rdStb) |=> stateQ == ST_AWAIT);

  // R6
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HALT && !clearViol) |=> stateQ == ST_HALT);

  // R7
  clear_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearViol |=> stateQ == ST_IDLE);
endmodule

// File: rtl/lsm_dpath.sv
module lsm_dpath
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  lsmStrobe_t        strobe,
  input  logic              clearViol,
  output logic              violSticky,
  output logic              violPulse,
  output violCause_e        violCause,
  output logic [ADDR_W-1:0] violAddr
);
  logic [ADDR_W-1:0] pendAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr   <= '0;
      violSticky <= 1'b0;
      violPulse  <= 1'b0;
      violCause  <= CAUSE_NONE;
      violAddr   <= '0;
    end else begin
      violPulse <= 1'b0;
      if (strobe.loadPend) pendAddr <= busAddr;
      if (strobe.clear) begin
        violSticky <= 1'b0;
        violCause  <= CAUSE_NONE;
        violAddr   <= '0;
      end else if (strobe.raise) begin
        violSticky <= 1'b1;
        violPulse  <= 1'b1;
        violCause  <= strobe.cause;
        violAddr   <= (strobe.cause == CAUSE_DOUBLE) ? busAddr : pendAddr;
      end
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |=> !violPulse);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violSticky && !clearViol) |=> (violSticky && $stable(violAddr) && $stable(violCause)));

  // R3
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> (violSticky && violCause != CAUSE_NONE));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearViol |=> (!violSticky && violAddr == '0));
endmodule

// File: rtl/lock_seq_monitor.sv
module lock_seq_monitor
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busLock,
  input  logic [CNT_W-1:0]  stallLimit,
  input  logic              clearViol,
  output logic              violSticky,
  output logic              violPulse,
  output logic [1:0]        violCause,
  output logic [ADDR_W-1:0] violAddr
);
  lsmStrobe_t strobe;
  violCause_e causeQ;

  lsm_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .busLock(busLock),
    .stallLimit(stallLimit), .clearViol(clearViol), .strobe(strobe)
  );

  lsm_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .strobe(strobe),
    .clearViol(clearViol), .violSticky(violSticky), .violPulse(violPulse),
    .violCause(causeQ), .violAddr(violAddr)
  );

  assign violCause = causeQ;
endmodule

// File: tb/lock_seq_monitor_tb.sv
module lock_seq_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStb = 1'b0, wrStb = 1'b0, busLock = 1'b0, clearViol = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [CNT_W-1:0] stallLimit = '0;
  logic violSticky, violPulse;
  logic [1:0] violCause;
  logic [ADDR_W-1:0] violAddr;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_seq_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .busAddr(busAddr),
    .busLock(busLock), .stallLimit(stallLimit), .clearViol(clearViol),
    .violSticky(violSticky), .violPulse(violPulse), .violCause(violCause),
    .violAddr(violAddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one bus cycle at the falling edge, then sample after the next rising edge
  task automatic cyc(input logic rd, input logic wr, input logic lk,
                     input logic [ADDR_W-1:0] a, input logic clr = 1'b0);
    @(negedge clk);
    rdStb = rd; wrStb = wr; busLock = lk; busAddr = a; clearViol = clr;
    @(posedge clk);
    #1;
    rdStb = 1'b0; wrStb = 1'b0; clearViol = 1'b0;
  endtask

  task automatic expectNone(input string req);
    chk(req, int'(violSticky), 0);
    chk(req, int'(violPulse), 0);
  endtask

  task automatic expectFault(input string req, input int cause, input int addr);
    chk(req, int'(violPulse), 1);
    chk(req, int'(violSticky), 1);
    chk(req, int'(violCause), cause);
    chk(req, int'(violAddr), addr);
  endtask

  task automatic doClear();
    cyc(0, 0, 0, '0, 1'b1);
    chk("R7", int'(violSticky), 0);
    chk("R7", int'(violCause), 0);
    chk("R7", int'(violAddr), 0);
  endtask

  task automatic testReset();
    chk("R8", int'(violSticky), 0);
    chk("R8", int'(violPulse), 0);
    chk("R8", int'(violCause), 0);
    chk("R8", int'(violAddr), 0);
  endtask

  task automatic testCleanPairs();
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 1, 16'h0040 + 16'(i));
      cyc(0, 1, 1, 16'h0040 + 16'(i));
      expectNone("R1");
    end
    cyc(0, 0, 0, '0);
    expectNone("R1");
  endtask

  task automatic testUnlocked();
    cyc(1, 0, 0, 16'h1000);
    cyc(1, 0, 0, 16'h1004);
    cyc(0, 1, 0, 16'h1008);
    expectNone("R2");
    // a following locked read/write pair is still clean, so nothing was opened
    cyc(1, 0, 1, 16'h1010);
    cyc(0, 1, 1, 16'h1010);
    cyc(0, 0, 0, '0);
    expectNone("R2");
  endtask

  task automatic testDoubleRead();
    cyc(1, 0, 1, 16'h0100);
    expectNone("R3");
    cyc(1, 0, 1, 16'h0104);
    expectFault("R3", 1, 16'h0104);
    cyc(1, 0, 1, 16'h0108);
    chk("R6", int'(violPulse), 0);
    chk("R6", int'(violSticky), 1);
    chk("R6", int'(violAddr), 16'h0104);
    cyc(0, 0, 0, '0);
    chk("R6", int'(violCause), 1);
    doClear();
  endtask

  task automatic testLockDrop();
    cyc(1, 0, 1, 16'h0200);
    cyc(0, 0, 0, 16'h0abc);
    expectFault("R4", 2, 16'h0200);
    cyc(0, 0, 0, '0);
    chk("R6", int'(violPulse), 0);
    doClear();
  endtask

  task automatic testStall();
    stallLimit = 8'd5;
    cyc(1, 0, 1, 16'h0300);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, '0);
    expectNone("R5");
    cyc(0, 0, 1, '0);
    expectFault("R5", 3, 16'h0300);
    cyc(0, 0, 0, '0);
    doClear();
    // disabled: long quiet locked stretch, then a clean close
    stallLimit = 8'd0;
    cyc(1, 0, 1, 16'h0310);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, '0);
    expectNone("R5");
    cyc(0, 1, 1, 16'h0310);
    cyc(0, 0, 0, '0);
    expectNone("R5");
  endtask

  task automatic testClearPriority();
    cyc(1, 0, 1, 16'h0400);
    cyc(1, 0, 1, 16'h0404);
    expectFault("R3", 1, 16'h0404);
    // clear together with a locked read: the read must be dropped
    cyc(1, 0, 1, 16'h0408, 1'b1);
    chk("R7", int'(violSticky), 0);
    cyc(1, 0, 1, 16'h040c);
    expectNone("R7");
    cyc(0, 1, 1, 16'h040c);
    cyc(0, 0, 0, '0);
    expectNone("R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCleanPairs();
    testUnlocked();
    testDoubleRead();
    testLockDrop();
    testStall();
    testClearPriority();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule